// File: doc/BRIEF.md
# Clock-Unit Lock Reset Sequencer

This block sits on a free-running reference clock and brings one or more on-chip clock-synthesis units out of reset. It pulses a reset to every unit, then waits a fixed window. At the end of the window it samples the units' lock indicators. If any unit is not locked, it pulses the reset again and repeats the attempt.

Downstream logic gets a synchronous system reset. This reset is held until every unit has reported lock for a run of consecutive cycles. If lock is lost later, the system reset is asserted again and the whole bring-up starts over. A saturating retry count and the current state are brought out for debug.

The sequencer has four states:
- PULSE (code 0): the units are held in reset.
- WAIT (code 1): fixed lock window.
- SETTLE (code 2): lock must hold steady.
- RUN (code 3): system reset released.

Transitions:
- PULSE→WAIT when the pulse length has elapsed.
- WAIT→SETTLE when all units are locked at the end of the window.
- WAIT→PULSE on a failed window.
- SETTLE→RUN after the stable count.
- SETTLE→PULSE on a lock drop.
- RUN→PULSE on a lock drop.
- Any state→PULSE on the asynchronous reset.

Top module: `clkmgr_bringup`

## Requirements
- R1: While `rst_n_i` is low, and immediately on its falling edge with no clock edge needed, `sys_rst_o` is 1, every bit of `unit_rst_o` is 1, `state_o` is 0 (PULSE) and `retry_o` is 0.
- R2: In each attempt, `unit_rst_o` is high for exactly PULSE_CYC reference cycles, counting from entry to PULSE. It then stays low for the whole wait window. `unit_rst_o` is never high while `sys_rst_o` is low.
- R3: The synchronised lock inputs are examined only at the end of a WAIT_CYC-cycle window. The attempt succeeds only if every unit is locked at that moment. Otherwise the sequencer returns to PULSE, and `unit_rst_o` rises WAIT_CYC cycles after it fell.
- R4: `retry_o` rises by one for each failed attempt and saturates at 2^RETRY_W−1. A failed attempt is either a failed window or a lock loss during SETTLE. It is cleared only by `rst_n_i`.
- R5: With every lock input high, `sys_rst_o` falls exactly WAIT_CYC+STABLE_CYC cycles after `unit_rst_o` falls. It falls on a reference clock edge, and only after all synchronised locks were high in the preceding cycle.
- R6: A lock drop on any unit during SETTLE sends the sequencer back to PULSE and increments `retry_o`. `sys_rst_o` stays high throughout.
- R7: A lock drop on any unit during RUN re-asserts `sys_rst_o` and `unit_rst_o` exactly 3 cycles after the drop: two synchroniser stages plus the state register. `retry_o` does not change.
- R8: `state_o` encodes the state as PULSE=0, WAIT=1, SETTLE=2, RUN=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Free-running reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| lock_i | input | N_UNITS | Lock indicators from the clock units (asynchronous) |
| unit_rst_o | output | N_UNITS | Reset to each clock unit, active high |
| sys_rst_o | output | 1 | Synchronous system reset, active high |
| retry_o | output | RETRY_W | Saturating count of failed attempts |
| state_o | output | 2 | Current sequencer state code |

## Verification
The assertions assume that the lock inputs may change at any time, but only reach the state machine through the two-flop synchronisers. They also assume that the asynchronous reset is the only way the retry count falls. The stimulus changes lock inputs and the reset only at the clock's falling edge, or in the middle of the low phase. The window, pulse and stable counts are shortened through parameters so that several complete attempts fit in a short run. Lock changes are timed relative to the observed fall of `unit_rst_o`, so each drop lands inside the intended state.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
    typedef enum logic [1:0] {
        SQ_PULSE  = 2'd0,
        SQ_WAIT   = 2'd1,
        SQ_SETTLE = 2'd2,
        SQ_RUN    = 2'd3
    } seq_state_t;
endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                sync_q <= meta_q;
            end
        end
        assign sync_o[g] = sync_q;
    end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    output logic [CW-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_o <= '0;
        else if (clear_i) count_o <= '0;
        else              count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/clkmgr_bringup.sv
module clkmgr_bringup
    import clkseq_pkg::*;
#(
    parameter int N_UNITS    = 2,
    parameter int PULSE_CYC  = 8,
    parameter int WAIT_CYC   = 65536,
    parameter int STABLE_CYC = 16,
    parameter int RETRY_W    = 4
) (
    input  logic               clk_ref_i,
    input  logic               rst_n_i,
    input  logic [N_UNITS-1:0] lock_i,
    output logic [N_UNITS-1:0] unit_rst_o,
    output logic               sys_rst_o,
    output logic [RETRY_W-1:0] retry_o,
    output logic [1:0]         state_o
);
    localparam int MAX_AB = (PULSE_CYC > STABLE_CYC) ? PULSE_CYC : STABLE_CYC;
    localparam int MAX_C  = (WAIT_CYC > MAX_AB) ? WAIT_CYC : MAX_AB;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] PULSE_END  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_END   = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] STABLE_END = CNT_W'(STABLE_CYC - 1);

    seq_state_t         state_q, state_d;
    logic [N_UNITS-1:0] lock_s;
    logic               all_lock;
    logic [CNT_W-1:0]   cnt;
    logic               fail_d;
    logic               unit_rst_q, sys_rst_q;
    logic [RETRY_W-1:0] retry_q;

    lock_sync #(.WIDTH(N_UNITS)) u_sync (
        .clk     (clk_ref_i),
        .rst_n   (rst_n_i),
        .async_i (lock_i),
        .sync_o  (lock_s)
    );

    assign all_lock = &lock_s;

    seq_timer #(.CW(CNT_W)) u_timer (
        .clk     (clk_ref_i),
        .rst_n   (rst_n_i),
        .clear_i (state_d != state_q),
        .count_o (cnt)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        fail_d  = 1'b0;
        unique case (state_q)
            SQ_PULSE:  if (cnt == PULSE_END) state_d = SQ_WAIT;
            SQ_WAIT:   if (cnt == WAIT_END) begin
                           if (all_lock) state_d = SQ_SETTLE;
                           else begin
                               state_d = SQ_PULSE;
                               fail_d  = 1'b1;
                           end
                       end
            SQ_SETTLE: if (!all_lock) begin
                           state_d = SQ_PULSE;
                           fail_d  = 1'b1;
                       end else if (cnt == STABLE_END) state_d = SQ_RUN;
            SQ_RUN:    if (!all_lock) state_d = SQ_PULSE;
            default:   state_d = SQ_PULSE;
        endcase
    end

    // state register
    always_ff @(posedge clk_ref_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= SQ_PULSE;
        else          state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk_ref_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            unit_rst_q <= 1'b1;
            sys_rst_q  <= 1'b1;
            retry_q    <= '0;
        end else begin
            unit_rst_q <= (state_d == SQ_PULSE);
            sys_rst_q  <= (state_d != SQ_RUN);
            if (fail_d && (retry_q != {RETRY_W{1'b1}}))
                retry_q <= retry_q + 1'b1;
        end
    end

    assign unit_rst_o = {N_UNITS{unit_rst_q}};
    assign sys_rst_o  = sys_rst_q;
    assign retry_o    = retry_q;
    assign state_o    = state_q;

    // R2: units are never held in reset while the system is released
    a_r2_unit_implies_sys: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
        unit_rst_q |-> sys_rst_q);

    // R3: the wait window is left only when the timer reaches its end
    a_r3_wait_full_window: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
        ($past(state_q) == SQ_WAIT && state_q != SQ_WAIT) |-> ($past(cnt) == WAIT_END));

    // R4: retry count never falls and steps by at most one
    a_r4_retry_step: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
        ({1'b0, retry_q} == {1'b0, $past(retry_q)}) ||
        ({1'b0, retry_q} == {1'b0, $past(retry_q)} + 1'b1));

    // R5: release only follows a cycle with every synchronised lock high
    a_r5_release_needs_lock: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
        !sys_rst_q |-> $past(all_lock));

    // R6: a loss during settle is counted unless saturated
    a_r6_settle_loss_counted: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
        ($past(state_q) == SQ_SETTLE && state_q == SQ_PULSE) |->
        (retry_q != $past(retry_q) || retry_q == {RETRY_W{1'b1}}));
endmodule

// File: tb/clkmgr_bringup_test.sv
module clkmgr_bringup_test;
    localparam int N   = 2;
    localparam int PC  = 4;
    localparam int WC  = 20;
    localparam int SC  = 5;
    localparam int RW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  lock_in = '0;
    logic [N-1:0]  unit_rst;
    logic          sys_rst;
    logic [RW-1:0] retry;
    logic [1:0]    state;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    clkmgr_bringup #(.N_UNITS(N), .PULSE_CYC(PC), .WAIT_CYC(WC),
                     .STABLE_CYC(SC), .RETRY_W(RW)) uut (
        .clk_ref_i (clk),
        .rst_n_i   (rst_n),
        .lock_i    (lock_in),
        .unit_rst_o(unit_rst),
        .sys_rst_o (sys_rst),
        .retry_o   (retry),
        .state_o   (state)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // reset held low, then released at a falling clock edge
    task automatic restart(input logic [N-1:0] locks);
        @(negedge clk);
        rst_n   = 1'b0;
        lock_in = locks;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        tick(2);
        check("R1 sys_rst in reset", sys_rst, 1);
        check("R1 unit_rst in reset", unit_rst, 3);
        check("R1 state PULSE in reset", state, 0);
        check("R1 retry zero in reset", retry, 0);
    endtask

    task automatic t_clean_bringup();
        int hi;
        int gap;
        restart(2'b11);
        hi = 0;
        while (unit_rst == 2'b11 && hi < 100) begin hi++; tick(1); end
        check("R2 pulse length", hi, PC);
        check("R2 unit_rst low after pulse", unit_rst, 0);
        gap = 0;
        while (sys_rst && gap < 200) begin
            if (gap == 5)  check("R8 state WAIT code", state, 1);
            if (gap == 5)  check("R2 unit_rst low in wait", unit_rst, 0);
            if (gap == 22) check("R8 state SETTLE code", state, 2);
            gap++;
            tick(1);
        end
        check("R5 release delay", gap, WC + SC);
        check("R8 state RUN code", state, 3);
        check("R4 no retry on clean start", retry, 0);
    endtask

    task automatic t_run_drop();
        lock_in[1] = 1'b0;
        tick(2);
        check("R7 sys_rst not early", sys_rst, 0);
        tick(1);
        check("R7 sys_rst reasserted", sys_rst, 1);
        check("R7 unit_rst reasserted", unit_rst, 3);
        check("R7 state PULSE", state, 0);
        check("R7 retry unchanged", retry, 0);
        lock_in[1] = 1'b1;
        tick(PC + WC + SC + 4);
        check("R7 recovered to RUN", sys_rst, 0);
    endtask

    task automatic t_async_in_run();
        #5 rst_n = 1'b0;
        #1;
        check("R1 sys_rst immediate", sys_rst, 1);
        check("R1 unit_rst immediate", unit_rst, 3);
        check("R1 state immediate", state, 0);
    endtask

    task automatic t_partial_lock();
        restart(2'b01);
        tick(PC + WC - 1);
        check("R3 still waiting", state, 1);
        check("R3 unit_rst low before window end", unit_rst, 0);
        tick(1);
        check("R3 partial lock retried", state, 0);
        check("R3 unit_rst rises again", unit_rst, 3);
        check("R4 retry counted", retry, 1);
        check("R3 sys_rst held", sys_rst, 1);
    endtask

    task automatic t_settle_drop();
        restart(2'b11);
        tick(PC + WC);
        check("R6 in SETTLE", state, 2);
        lock_in[0] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick(1);
            check("R6 sys_rst held", sys_rst, 1);
        end
        check("R6 back to PULSE", state, 0);
        check("R6 retry counted", retry, 1);
    endtask

    task automatic t_saturate();
        restart(2'b00);
        tick((PC + WC) * 5 + 2);
        check("R4 retry saturated", retry, 3);
        check("R3 no release without lock", sys_rst, 1);
        #5 rst_n = 1'b0;
        #1;
        check("R1 retry cleared", retry, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_clean_bringup();
        t_run_drop();
        t_async_in_run();
        t_partial_lock();
        t_settle_drop();
        t_saturate();
        finish_run();
    end
endmodule